// File: doc/BRIEF.md
# Four-Channel DMA Controller Register Block

This block is the byte-wide, port-mapped register interface of a four-channel DMA controller of the classic PC kind. Software reaches it through a 4-bit I/O window with 8-bit data and separate read and write strobes. Each channel holds a 16-bit base address, a current address, a base count and a current count. Software reads and writes these registers one byte at a time. A single pointer flip-flop, shared by all channels, decides which byte each access reaches. Further offsets hold the mode, mask, request, command and status registers.

The transfer engine outside the block reports each completed transfer with a one-cycle `xfer_done` pulse and the channel number. For that channel the block steps the current address, counts the current count down and detects terminal count. At terminal count it either reloads the channel from its base registers or masks the channel. The engine also reads the decoded transfer type and mode of the channel it has selected.

Top module: `dma4_regfile`

## Requirements
- R1: After reset, all four channel masks are set, the byte pointer selects the low byte, and status, request and all address and count registers read zero. `rdata` is zero, and `eop` is low.
- R2: Offset 2n is channel n's address register and offset 2n+1 is its count register (n = 0..3). A write loads both the base and the current copy. A read returns the current copy one cycle after the `rd` strobe. The first access reaches the low byte and the next access reaches the high byte, because one shared pointer toggles on every read or write to offsets 0x0..0x7.
- R3: A write of any value to offset 0xC returns the byte pointer to the low byte.
- R4: A write to offset 0xA takes the channel from bits 1:0. Bit 2 = 1 masks that channel and bit 2 = 0 unmasks it. The other channels are unchanged.
- R5: A write to offset 0xF copies bits 3:0 into the masks of channels 3..0. A write of any value to offset 0xE clears all four masks.
- R6: A write to offset 0xB stores a mode for the channel in bits 1:0. The fields are: bits 3:2 transfer type (01 I/O to memory, 10 memory to I/O), bit 4 auto-initialize, bit 5 address decrement, bits 7:6 mode (01 single, 11 cascade). For the channel on `xfer_chan`, `act_type` shows bits 3:2 and `act_mode` shows bits 7:6. So 0x44 gives 01/01, 0x48 gives 10/01 and 0xC0 gives 00/11.
- R7: An `xfer_done` pulse acts on the channel on `xfer_chan` only when that channel is unmasked and command bit 2 is clear. It then adds 1 to the current address (subtracts 1 when mode bit 5 is set) and subtracts 1 from the current count. Otherwise the pulse has no effect.
- R8: A programmed count of N gives N+1 transfers. Terminal count is the transfer that takes the count from 0x0000 to 0xFFFF, and `eop` is high for one cycle after that pulse. Without auto-initialize, the count then reads back 0xFFFF.
- R9: At terminal count the channel's status bit (bits 3:0) is set. With auto-initialize, both current registers reload from the base registers and the mask is unchanged. Without it, the channel's mask bit is set. A terminal count takes priority over a mask write in the same cycle.
- R10: A read of offset 0x8 returns the pending requests of channels 3..0 in bits 7:4, each the software request OR the `hreq` input, and the terminal-count flags in bits 3:0. The read then clears bits 3:0.
- R11: A write to offset 0x9 sets the software request of the channel in bits 1:0 when bit 2 = 1, and clears it when bit 2 = 0.
- R12: A write to offset 0xD (master clear) clears the byte pointer, command, status and requests, and sets all four masks. Mode and address registers keep their values. A read of 0xD returns the temporary register, which is zero. Reads of the other write-only offsets return zero.
- R13: A write to offset 0x8 stores the command byte. While its bit 2 is set, every `xfer_done` pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one cycle per access |
| rd | input | 1 | Read strobe, one cycle per access |
| rdata | output | 8 | Registered read data, valid the cycle after `rd` |
| hreq | input | 4 | Hardware request lines of channels 3..0 |
| xfer_done | input | 1 | One-cycle pulse per completed transfer |
| xfer_chan | input | 2 | Channel of the transfer and of the `act_*` outputs |
| chan_mask | output | 4 | Mask bits of channels 3..0 |
| eop | output | 1 | Registered terminal-count pulse |
| act_type | output | 2 | Transfer type of the channel on `xfer_chan` |
| act_mode | output | 2 | Mode field of the channel on `xfer_chan` |

## Verification
The bench builds the block with its default 8-bit data path, so every register is 16 bits wide and is reached in exactly two byte accesses. Small programmed counts bring terminal count, reload and auto-masking within a handful of pulses. Random high-byte writes and long random runs carry the address and count registers across their 16-bit wrap points. A long random mix of writes to every offset, status reads and transfer pulses keeps the shared byte pointer out of step with the channel under access, so any place where the pointer toggles wrongly shows up in later reads.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  // The address map (2n / 2n+1 for n < 4, control at 0x8..0xF) fixes the channel count
  localparam int NCH = 4;
  localparam int CW  = 2;

  localparam logic [3:0] OFS_CMD     = 4'h8;
  localparam logic [3:0] OFS_REQ     = 4'h9;
  localparam logic [3:0] OFS_ONEMASK = 4'hA;
  localparam logic [3:0] OFS_MODE    = 4'hB;
  localparam logic [3:0] OFS_PTRCLR  = 4'hC;
  localparam logic [3:0] OFS_MCLR    = 4'hD;
  localparam logic [3:0] OFS_UNMASK  = 4'hE;
  localparam logic [3:0] OFS_MASKALL = 4'hF;

  // Stored mode byte bits 7:2; bits 1:0 only select the channel
  typedef struct packed {
    logic [1:0] kind;      // 7:6
    logic       dec;       // 5
    logic       autoinit;  // 4
    logic [1:0] xtype;     // 3:2
  } mode_t;
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_addr,
  input  logic            we_cnt,
  input  logic            hi,
  input  logic [DW-1:0]   wdata,
  input  logic            step,
  input  logic            dec,
  input  logic            autoinit,
  output logic [2*DW-1:0] cur_addr,
  output logic [2*DW-1:0] cur_cnt,
  output logic            tc
);
  localparam int WW = 2 * DW;

  logic [WW-1:0] base_addr, base_cnt;

  assign tc = step && (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
    end else begin
      if (step) begin
        if (tc && autoinit) begin
          cur_addr <= base_addr;
          cur_cnt  <= base_cnt;
        end else begin
          cur_addr <= dec ? cur_addr - 1'b1 : cur_addr + 1'b1;
          cur_cnt  <= cur_cnt - 1'b1;
        end
      end
      if (we_addr) begin
        if (hi) begin
          base_addr[WW-1:DW] <= wdata;
          cur_addr[WW-1:DW]  <= wdata;
        end else begin
          base_addr[DW-1:0]  <= wdata;
          cur_addr[DW-1:0]   <= wdata;
        end
      end
      if (we_cnt) begin
        if (hi) begin
          base_cnt[WW-1:DW] <= wdata;
          cur_cnt[WW-1:DW]  <= wdata;
        end else begin
          base_cnt[DW-1:0]  <= wdata;
          cur_cnt[DW-1:0]   <= wdata;
        end
      end
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step && !we_cnt) |=> $stable(cur_cnt)); // R7
  AST_TC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && !autoinit && !we_cnt && cur_cnt == '0) |=> (cur_cnt == '1)); // R8
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      addr,
  input  logic [DW-1:0]   wdata,
  input  logic            wr,
  input  logic            rd,
  input  logic [NCH-1:0]  tc_vec,
  output logic            ptr_hi,
  output logic            cmd_dis,
  output logic [NCH-1:0]  mask,
  output logic [NCH-1:0]  req,
  output logic [NCH-1:0]  tcs,
  output mode_t           mode [NCH]
);
  logic [NCH-1:0] auto_vec, mask_n, tcs_n;
  logic           mclr, reg_acc;

  for (genvar i = 0; i < NCH; i++) begin : g_auto
    assign auto_vec[i] = mode[i].autoinit;
  end

  assign mclr    = wr && (addr == OFS_MCLR);
  assign reg_acc = (wr || rd) && !addr[3];

  always_comb begin
    mask_n = mask;
    if (wr && addr == OFS_ONEMASK) mask_n[wdata[CW-1:0]] = wdata[2];
    if (wr && addr == OFS_UNMASK)  mask_n = '0;
    if (wr && addr == OFS_MASKALL) mask_n = wdata[NCH-1:0];
    mask_n = mask_n | (tc_vec & ~auto_vec);
  end

  always_comb begin
    tcs_n = (rd && addr == OFS_CMD) ? '0 : tcs;
    tcs_n = tcs_n | tc_vec;
  end

  always_ff @(posedge clk) begin
    if (rst || mclr) begin
      ptr_hi  <= 1'b0;
      cmd_dis <= 1'b0;
      req     <= '0;
      tcs     <= '0;
      mask    <= '1;
    end else begin
      mask <= mask_n;
      tcs  <= tcs_n;
      if (wr && addr == OFS_PTRCLR) ptr_hi <= 1'b0;
      else if (reg_acc)             ptr_hi <= ~ptr_hi;
      if (wr && addr == OFS_CMD)    cmd_dis <= wdata[2];
      if (wr && addr == OFS_REQ)    req[wdata[CW-1:0]] <= wdata[2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) mode[i] <= '0;
    end else if (wr && addr == OFS_MODE) begin
      mode[wdata[CW-1:0]] <= mode_t'(wdata[7:2]);
    end
  end

  AST_PTR_LOW: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == OFS_PTRCLR) |=> !ptr_hi); // R3
  AST_MCLR_STATE: assert property (@(posedge clk) disable iff (rst)
    mclr |=> (mask == '1 && tcs == '0 && req == '0 && !cmd_dis)); // R12
  AST_NOAUTO_MASK: assert property (@(posedge clk) disable iff (rst)
    (|(tc_vec & ~auto_vec)) |=>
      ((mask & $past(tc_vec & ~auto_vec)) == $past(tc_vec & ~auto_vec))); // R9
  AST_STAT_CLR: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == OFS_CMD && tc_vec == '0 && !mclr) |=> (tcs == '0)); // R10
endmodule

// File: rtl/dma4_regfile.sv
module dma4_regfile
  import dma4_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [3:0]     addr,
  input  logic [DW-1:0]  wdata,
  input  logic           wr,
  input  logic           rd,
  output logic [DW-1:0]  rdata,
  input  logic [NCH-1:0] hreq,
  input  logic           xfer_done,
  input  logic [CW-1:0]  xfer_chan,
  output logic [NCH-1:0] chan_mask,
  output logic           eop,
  output logic [1:0]     act_type,
  output logic [1:0]     act_mode
);
  localparam int WW = 2 * DW;

  logic           ptr_hi, cmd_dis;
  logic [NCH-1:0] mask, req, tcs, tc_vec;
  mode_t          mode [NCH];
  logic [WW-1:0]  cur_addr [NCH];
  logic [WW-1:0]  cur_cnt  [NCH];
  logic [WW-1:0]  sel_word;
  logic [DW-1:0]  rd_mux;

  dma4_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .tc_vec(tc_vec), .ptr_hi(ptr_hi), .cmd_dis(cmd_dis), .mask(mask),
    .req(req), .tcs(tcs), .mode(mode)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic hit, step;
    assign hit  = !addr[3] && (addr[CW:1] == CW'(i));
    assign step = xfer_done && (xfer_chan == CW'(i)) && !mask[i] && !cmd_dis;
    dma4_chan #(.DW(DW)) u_chan (
      .clk(clk), .rst(rst),
      .we_addr(wr && hit && !addr[0]), .we_cnt(wr && hit && addr[0]),
      .hi(ptr_hi), .wdata(wdata), .step(step),
      .dec(mode[i].dec), .autoinit(mode[i].autoinit),
      .cur_addr(cur_addr[i]), .cur_cnt(cur_cnt[i]), .tc(tc_vec[i])
    );
  end

  always_comb begin
    sel_word = addr[0] ? cur_cnt[addr[CW:1]] : cur_addr[addr[CW:1]];
    if (!addr[3])            rd_mux = ptr_hi ? sel_word[WW-1:DW] : sel_word[DW-1:0];
    else if (addr == OFS_CMD) rd_mux = DW'({req | hreq, tcs});
    else                      rd_mux = '0;  // temporary register and write-only offsets
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      eop   <= 1'b0;
    end else begin
      if (rd) rdata <= rd_mux;
      eop <= |tc_vec;
    end
  end

  assign chan_mask = mask;
  assign act_type  = mode[xfer_chan].xtype;
  assign act_mode  = mode[xfer_chan].kind;

  AST_EOP_STATUS: assert property (@(posedge clk) disable iff (rst)
    eop |-> (tcs != '0 || $past(wr && addr == OFS_MCLR))); // R9
  AST_EOP_ONE: assert property (@(posedge clk) disable iff (rst)
    !xfer_done |=> !eop); // R8
endmodule

// File: tb/tb_dma4_regfile.sv
module tb_dma4_regfile;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic [3:0] hreq = '0;
  logic       xfer_done = 1'b0;
  logic [1:0] xfer_chan = '0;
  logic [3:0] chan_mask;
  logic       eop;
  logic [1:0] act_type, act_mode;

  int nchk = 0, nerr = 0;
  bit done = 0;

  logic [15:0] mba [4], mca [4], mbc [4], mcc [4];
  logic [5:0]  mmode [4];
  logic [3:0]  mmask, mreq, mtcs;
  logic        mptr, mdis;

  always #5 clk = ~clk;

  dma4_regfile dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .hreq(hreq), .xfer_done(xfer_done), .xfer_chan(xfer_chan),
    .chan_mask(chan_mask), .eop(eop), .act_type(act_type), .act_mode(act_mode)
  );

  task automatic chk(input string tag, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic model_clr();
    for (int i = 0; i < 4; i++) begin
      mba[i] = '0; mca[i] = '0; mbc[i] = '0; mcc[i] = '0; mmode[i] = '0;
    end
    mmask = 4'hF; mreq = '0; mtcs = '0; mptr = 0; mdis = 0;
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    int ch;
    ch = a[2:1];
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    if (!a[3]) begin
      if (!a[0]) begin
        if (mptr) begin mba[ch][15:8] = d; mca[ch][15:8] = d; end
        else      begin mba[ch][7:0]  = d; mca[ch][7:0]  = d; end
      end else begin
        if (mptr) begin mbc[ch][15:8] = d; mcc[ch][15:8] = d; end
        else      begin mbc[ch][7:0]  = d; mcc[ch][7:0]  = d; end
      end
      mptr = ~mptr;
    end else begin
      case (a)
        4'h8: mdis = d[2];
        4'h9: mreq[d[1:0]] = d[2];
        4'hA: mmask[d[1:0]] = d[2];
        4'hB: mmode[d[1:0]] = d[7:2];
        4'hC: mptr = 0;
        4'hD: begin mptr = 0; mdis = 0; mreq = '0; mtcs = '0; mmask = 4'hF; end
        4'hE: mmask = '0;
        default: mmask = d[3:0];
      endcase
    end
    chk("R4/R5/R12 chan_mask after write", chan_mask, mmask);
  endtask

  task automatic do_rd(input logic [3:0] a, input string tag);
    logic [7:0]  e;
    logic [15:0] w;
    int ch;
    ch = a[2:1];
    if (!a[3]) begin
      w = a[0] ? mcc[ch] : mca[ch];
      e = mptr ? w[15:8] : w[7:0];
      mptr = ~mptr;
    end else if (a == 4'h8) begin
      e = {mreq | hreq, mtcs};
      mtcs = '0;
    end else begin
      e = '0;
    end
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    chk(tag, rdata, e);
  endtask

  task automatic do_xfer(input logic [1:0] c);
    logic tc, au;
    tc = 0;
    au = mmode[c][2];
    if (!mmask[c] && !mdis) begin
      tc = (mcc[c] == 16'h0);
      if (tc && au) begin
        mca[c] = mba[c]; mcc[c] = mbc[c];
      end else begin
        mca[c] = mmode[c][3] ? mca[c] - 16'd1 : mca[c] + 16'd1;
        mcc[c] = mcc[c] - 16'd1;
      end
      if (tc) begin
        mtcs[c] = 1'b1;
        if (!au) mmask[c] = 1'b1;
      end
    end
    @(negedge clk); xfer_chan = c; xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    chk("R8 eop after transfer pulse", eop, tc);
    chk("R9 chan_mask after transfer", chan_mask, mmask);
  endtask

  task automatic chk_act(input logic [1:0] c);
    @(negedge clk); xfer_chan = c;
    #1;
    chk("R6 act_type", act_type, mmode[c][1:0]);
    chk("R6 act_mode", act_mode, mmode[c][5:4]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    model_clr();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 mask after reset", chan_mask, 4'hF);
    chk("R1 rdata after reset", rdata, 0);
    chk("R1 eop after reset", eop, 0);
    do_rd(4'h8, "R1 status after reset");
    do_rd(4'h2, "R1 addr low after reset");
    do_rd(4'h2, "R1 addr high after reset");

    // R2 channel 1 programming, R3 pointer clear
    do_wr(4'hC, 8'h00);
    do_wr(4'h2, 8'h99);
    do_wr(4'hC, 8'h5A);               // R3 back to low byte
    do_wr(4'h2, 8'h34);
    do_wr(4'h2, 8'h12);
    do_wr(4'h3, 8'h02);
    do_wr(4'h3, 8'h00);
    do_rd(4'h2, "R2 addr low");
    do_rd(4'h2, "R2 addr high");
    chk("R3 model addr after clear", mca[1], 16'h1234);
    // R6 mode decode 0x44 on ch1, 0x48 on ch2, 0xC0 on ch3
    do_wr(4'hB, 8'h45);
    do_wr(4'hB, 8'h4A);
    do_wr(4'hB, 8'hC3);
    chk_act(2'd1); chk("R6 0x44 type", act_type, 2'b01);
    chk_act(2'd2); chk("R6 0x48 type", act_type, 2'b10);
    chk_act(2'd3); chk("R6 0xC0 mode", act_mode, 2'b11);
    // R7 masked channel ignores pulse
    do_xfer(2'd1);
    do_rd(4'h3, "R7 count unchanged while masked lo");
    do_rd(4'h3, "R7 count unchanged while masked hi");
    // R4 unmask ch1, R8 three transfers for N=2
    do_wr(4'hA, 8'h01);
    do_xfer(2'd1); do_xfer(2'd1); do_xfer(2'd1);
    do_rd(4'h3, "R8 count low after completion");
    do_rd(4'h3, "R8 count high after completion");
    do_rd(4'h2, "R7 addr low after increments");
    do_rd(4'h2, "R7 addr high after increments");
    do_rd(4'h8, "R10 status with tc flag");
    do_rd(4'h8, "R10 status cleared by read");
    // R9 autoinit with decrement on ch2
    do_wr(4'hB, 8'h7A);
    do_wr(4'h4, 8'h10); do_wr(4'h4, 8'h00);
    do_wr(4'h5, 8'h01); do_wr(4'h5, 8'h00);
    do_wr(4'hA, 8'h02);
    do_xfer(2'd2); do_xfer(2'd2);
    do_rd(4'h4, "R9 reload addr low"); do_rd(4'h4, "R9 reload addr high");
    do_rd(4'h5, "R9 reload count low"); do_rd(4'h5, "R9 reload count high");
    do_xfer(2'd2);
    do_rd(4'h4, "R7 decrement addr low"); do_rd(4'h4, "R7 decrement addr high");
    // R13 command disable
    do_wr(4'h8, 8'h04);
    do_xfer(2'd2);
    do_rd(4'h4, "R13 addr held lo"); do_rd(4'h4, "R13 addr held hi");
    do_wr(4'h8, 8'h00);
    // R11 request and hreq
    do_wr(4'h9, 8'h06);
    hreq = 4'b1000;
    do_rd(4'h8, "R11 status request bits");
    do_wr(4'h9, 8'h02);
    do_rd(4'h8, "R11 request cleared");
    hreq = '0;
    // R5 mask all / clear masks
    do_wr(4'hF, 8'hA5);
    do_wr(4'hE, 8'hFF);
    // R12 master clear
    do_wr(4'h9, 8'h05);
    do_wr(4'h2, 8'h77);
    do_wr(4'hD, 8'h00);
    do_wr(4'h2, 8'h11);
    do_rd(4'h2, "R12 pointer low after master clear");
    do_rd(4'h8, "R12 status after master clear");
    do_rd(4'hD, "R12 temporary register");
    do_rd(4'hB, "R12 write-only offset reads zero");

    // random phase
    void'($urandom(32'd2024));
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [3:0] a;
      op = $urandom % 10;
      hreq = 4'($urandom);
      a = 4'($urandom);
      if (op < 4) begin
        if (a == 4'hD && ($urandom % 6) != 0) a = 4'hA;
        do_wr(a, 8'($urandom));
      end else if (op < 7) begin
        do_rd(a, "R2/R10 random read");
      end else if (op < 9) begin
        do_xfer(2'($urandom));
      end else begin
        chk_act(2'($urandom));
      end
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule